// File: doc/BRIEF.md
# Buffer Event and Interrupt Unit

This unit gathers the buffer-related events of a 10 Mb/s Ethernet controller into one read-only 16-bit status word and drives a single interrupt line. Single-cycle strobes from the receive path, the transmit path, the slave DMA engine and software each latch a sticky event bit. A 16-bit enable word chooses which latched events reach the interrupt. The host reads the status word with a one-cycle read strobe, and that read clears the event bits.

Two early-receive indications follow one accepted frame. An "address accepted" bit is set first. Once 128 bytes of the frame have arrived, it gives way to a "128 bytes received" bit. Two 10-bit counters track lost receive frames and transmit-time collisions. Each counter raises its own overflow event only when it steps from 1FFh to 200h.

Top module: `buf_event_irq`

## Requirements
- R1: The low six bits [5:0] of the status word always read 6'b001100. The low six bits of the enable word always read 6'b001011 and cannot be written. After reset the enable word reads 16'h000B and the status word reads 16'h000C.
- R2: A write to the enable word stores bits [15:6] of the written value. Reading it back returns those bits above the fixed low six bits.
- R3: Each strobe sets a sticky status bit that is visible on the clock edge that samples it: `sw_irq` sets bit 6, `dma_done` sets bit 7, `tx_rdy` sets bit 8 and `rx_miss` sets bit 10. The bit stays set until the status word is read.
- R4: A cycle with `stat_rd` high returns the current status word and clears every event bit at that edge. An event strobed in the same cycle as the read remains set afterwards.
- R5: `rx_dest_ok` sets bit 15. For a frame opened by `rx_sof` that has passed the address check, the 128th `rx_byte` clears bit 15 and sets bit 11, once per frame. A frame that never passes the address check sets neither bit.
- R6: Each `rx_miss` increments `miss_count`. The step from 10'h1FF to 10'h200 sets status bit 12. The wrap from 10'h3FF to 10'h000 sets nothing.
- R7: Each rising edge of `rx_carrier` while `tx_busy` is high increments `col_count`. A rise while idle, or a carrier held high, does not count. The step from 10'h1FF to 10'h200 sets status bit 13.
- R8: `irq` is registered. It goes high one cycle after an event bit whose enable bit (same position) is set, and it goes low one cycle after the read that clears that bit.
- R9: The enable for bit 11 is treated as cleared while `auto_dma` or `dma_only` is high. Bit 11 still latches in that case.
- R10: Reset clears both counters, all event bits and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Enable word write strobe |
| cfg_wdata | input | 16 | Enable word write data |
| cfg_rdata | output | 16 | Enable word read value |
| stat_rd | input | 1 | Status read strobe (read clears) |
| stat_rdata | output | 16 | Status word |
| sw_irq | input | 1 | Software interrupt request strobe |
| dma_done | input | 1 | Frame moved by slave DMA strobe |
| tx_rdy | input | 1 | Transmitter ready for a frame strobe |
| rx_miss | input | 1 | Frame lost for lack of buffer strobe |
| rx_sof | input | 1 | Start of a received frame |
| rx_dest_ok | input | 1 | Destination filter pass strobe |
| rx_byte | input | 1 | One received byte strobe |
| tx_busy | input | 1 | Transmission in progress (level) |
| rx_carrier | input | 1 | Receive activity (level) |
| auto_dma | input | 1 | Automatic receive DMA mode (level) |
| dma_only | input | 1 | DMA-only receive mode (level) |
| miss_count | output | 10 | Receive miss counter |
| col_count | output | 10 | Transmit collision counter |
| irq | output | 1 | Interrupt request |

## Verification
Every event bit and counter value shows up on the clock edge that samples its strobe, so the bench drives a strobe at a falling edge and reads the status word at the next falling edge. `irq` is one register further on, so the bench checks it one cycle after the status bit appears and one cycle after the clearing read. The 128-byte swap is checked just before and just after the 128th byte. The counter transitions 1FFh→200h and 3FFh→000h are reached by holding a strobe for a computed number of cycles, and the bench tracks the expected count on its own.

// File: rtl/buf_event_irq.sv
module buf_event_irq #(
  parameter int CNT_W       = 10,
  parameter int EARLY_BYTES = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  input  logic             stat_rd,
  output logic [15:0]      stat_rdata,
  input  logic             sw_irq,
  input  logic             dma_done,
  input  logic             tx_rdy,
  input  logic             rx_miss,
  input  logic             rx_sof,
  input  logic             rx_dest_ok,
  input  logic             rx_byte,
  input  logic             tx_busy,
  input  logic             rx_carrier,
  input  logic             auto_dma,
  input  logic             dma_only,
  output logic [CNT_W-1:0] miss_count,
  output logic [CNT_W-1:0] col_count,
  output logic             irq
);

  localparam int BC_W = $clog2(EARLY_BYTES + 1);
  localparam logic [CNT_W-1:0] OVF_FROM = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [BC_W-1:0]  LAST_B   = BC_W'(EARLY_BYTES - 1);
  localparam logic [BC_W-1:0]  SAT_B    = BC_W'(EARLY_BYTES);

  logic [15:6] evt_q, evt_d, set_v, en_q, en_eff;
  logic [BC_W-1:0] byte_cnt;
  logic accept_q, carrier_q, irq_q;

  wire col_evt  = tx_busy & rx_carrier & ~carrier_q;
  wire hit128   = rx_byte & ~rx_sof & (accept_q | rx_dest_ok) & (byte_cnt == LAST_B);
  wire miss_ovf = rx_miss & (miss_count == OVF_FROM);
  wire col_ovf  = col_evt & (col_count == OVF_FROM);

  assign stat_rdata = {evt_q, 6'b001100};
  assign cfg_rdata  = {en_q, 6'b001011};
  assign irq        = irq_q;

  always_comb begin
    set_v      = '0;
    set_v[6]   = sw_irq;
    set_v[7]   = dma_done;
    set_v[8]   = tx_rdy;
    set_v[10]  = rx_miss;
    set_v[11]  = hit128;
    set_v[12]  = miss_ovf;
    set_v[13]  = col_ovf;
    set_v[15]  = rx_dest_ok;
    evt_d      = (stat_rd ? '0 : evt_q) | set_v;
    if (hit128 && !rx_dest_ok) evt_d[15] = 1'b0;
    en_eff     = en_q;
    en_eff[11] = en_q[11] & ~(auto_dma | dma_only);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q      <= '0;
      en_q       <= '0;
      irq_q      <= 1'b0;
      carrier_q  <= 1'b0;
      miss_count <= '0;
      col_count  <= '0;
    end else begin
      evt_q     <= evt_d;
      irq_q     <= |(evt_q & en_eff);
      carrier_q <= rx_carrier;
      if (cfg_we)  en_q       <= cfg_wdata[15:6];
      if (rx_miss) miss_count <= miss_count + 1'b1;
      if (col_evt) col_count  <= col_count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_cnt <= '0;
      accept_q <= 1'b0;
    end else if (rx_sof) begin
      byte_cnt <= '0;
      accept_q <= 1'b0;
    end else begin
      if (rx_dest_ok) accept_q <= 1'b1;
      if (rx_byte && byte_cnt != SAT_B) byte_cnt <= byte_cnt + 1'b1;
    end
  end

  // R6
  miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_miss |=> miss_count == $past(miss_count) + 1'b1);

  // R6
  miss_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_miss && miss_count == OVF_FROM) |=> evt_q[12]);

  // R7
  col_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && rx_carrier && !carrier_q && col_count == OVF_FROM) |=> evt_q[13]);

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !sw_irq && !dma_done && !tx_rdy && !rx_miss && !rx_dest_ok
     && !rx_byte && !rx_carrier) |=> evt_q == '0);

  // R5
  early_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit128 && !rx_dest_ok && !stat_rd) |=> (evt_q[11] && !evt_q[15]));

  // R8
  irq_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q[6] && en_q[6]) |=> irq);

  // R9
  rx128_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((auto_dma || dma_only) && ((evt_q & en_q) & ~(10'b1 << 5)) == '0) |=> !irq);

endmodule

// File: tb/test_buf_event_irq.sv
module test_buf_event_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, stat_rd = 0, sw_irq = 0, dma_done = 0, tx_rdy = 0, rx_miss = 0;
  logic rx_sof = 0, rx_dest_ok = 0, rx_byte = 0, tx_busy = 0, rx_carrier = 0;
  logic auto_dma = 0, dma_only = 0;
  logic [15:0] cfg_wdata = '0, cfg_rdata, stat_rdata;
  logic [9:0] miss_count, col_count;
  logic irq;
  int checks = 0, errors = 0;
  int exp_miss = 0;
  logic done = 1'b0;

  buf_event_irq i_buf_event_irq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .stat_rd(stat_rd), .stat_rdata(stat_rdata), .sw_irq(sw_irq), .dma_done(dma_done),
    .tx_rdy(tx_rdy), .rx_miss(rx_miss), .rx_sof(rx_sof), .rx_dest_ok(rx_dest_ok),
    .rx_byte(rx_byte), .tx_busy(tx_busy), .rx_carrier(rx_carrier), .auto_dma(auto_dma),
    .dma_only(dma_only), .miss_count(miss_count), .col_count(col_count), .irq(irq));

  always #5 clk = ~clk;

  // {enable[15:0], stim {sw,dma,rdy,miss,dest}, expected status[15:0], expected irq}
  localparam logic [37:0] VEC [0:6] = '{
    {16'h0040, 5'b10000, 16'h004C, 1'b1},
    {16'h0000, 5'b10000, 16'h004C, 1'b0},
    {16'h0080, 5'b01000, 16'h008C, 1'b1},
    {16'h0100, 5'b01100, 16'h018C, 1'b1},
    {16'h0400, 5'b00010, 16'h040C, 1'b1},
    {16'h8000, 5'b00001, 16'h800C, 1'b1},
    {16'h0040, 5'b01000, 16'h008C, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v; tick(); cfg_we = 1'b0;
  endtask

  task automatic clr();
    stat_rd = 1'b1; tick(); stat_rd = 1'b0; tick();
  endtask

  task automatic frame128(input logic exp_irq, input string req);
    rx_sof = 1'b1; tick(); rx_sof = 1'b0;
    rx_dest_ok = 1'b1; tick(); rx_dest_ok = 1'b0;
    chk("R5 dest bit", stat_rdata, 16'h800C);
    rx_byte = 1'b1;
    repeat (127) tick();
    chk("R5 before 128th byte", stat_rdata, 16'h800C);
    tick(); rx_byte = 1'b0;
    chk("R5 after 128th byte", stat_rdata, 16'h080C);
    tick();
    chk(req, {15'd0, irq}, {15'd0, exp_irq});
    clr();
    rx_byte = 1'b1; repeat (10) tick(); rx_byte = 1'b0; tick();
    chk("R5 once per frame", stat_rdata, 16'h000C);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R10 / R1 reset state
    chk("R1 status reset", stat_rdata, 16'h000C);
    chk("R1 enable reset", cfg_rdata, 16'h000B);
    chk("R10 miss count reset", {6'd0, miss_count}, 16'h0000);
    chk("R10 col count reset", {6'd0, col_count}, 16'h0000);
    chk("R10 irq reset", {15'd0, irq}, 16'h0000);

    // R2 enable write, low bits fixed
    wr_cfg(16'hFFFF);
    chk("R2 enable readback", cfg_rdata, 16'hFFCB);
    wr_cfg(16'h0000);
    chk("R2 enable cleared", cfg_rdata, 16'h000B);

    // R3 / R8 / R4 vector table
    for (int i = 0; i < 7; i++) begin
      wr_cfg(VEC[i][37:22]);
      {sw_irq, dma_done, tx_rdy, rx_miss, rx_dest_ok} = VEC[i][21:17];
      if (VEC[i][18]) exp_miss++;
      tick();
      {sw_irq, dma_done, tx_rdy, rx_miss, rx_dest_ok} = 5'b0;
      chk("R3 event bit", stat_rdata, VEC[i][16:1]);
      tick();
      chk("R8 irq level", {15'd0, irq}, {15'd0, VEC[i][0]});
      clr();
      chk("R4 read clears", stat_rdata, 16'h000C);
      chk("R8 irq drops", {15'd0, irq}, 16'h0000);
    end

    // R4 event in the read cycle survives
    wr_cfg(16'h0000);
    sw_irq = 1'b1; stat_rd = 1'b1; tick();
    sw_irq = 1'b0; stat_rd = 1'b0;
    chk("R4 same-cycle event kept", stat_rdata, 16'h004C);
    clr();

    // R5 / R9 early receive
    wr_cfg(16'h0800);
    auto_dma = 1'b1;
    frame128(1'b0, "R9 masked by auto_dma");
    auto_dma = 1'b0; dma_only = 1'b1;
    frame128(1'b0, "R9 masked by dma_only");
    dma_only = 1'b0;
    frame128(1'b1, "R9 enabled irq");
    rx_sof = 1'b1; tick(); rx_sof = 1'b0;
    rx_byte = 1'b1; repeat (130) tick(); rx_byte = 1'b0; tick();
    chk("R5 no address pass", stat_rdata, 16'h000C);
    wr_cfg(16'h0000);

    // R6 miss counter
    rx_miss = 1'b1; repeat (16'h1FF - exp_miss) tick(); rx_miss = 1'b0;
    exp_miss = 'h1FF;
    chk("R6 count to 1FF", {6'd0, miss_count}, 16'h01FF);
    chk("R6 no overflow yet", stat_rdata, 16'h040C);
    clr();
    wr_cfg(16'h1000);
    rx_miss = 1'b1; tick(); rx_miss = 1'b0;
    chk("R6 overflow bit", stat_rdata, 16'h140C);
    chk("R6 count 200", {6'd0, miss_count}, 16'h0200);
    tick();
    chk("R6 overflow irq", {15'd0, irq}, 16'h0001);
    clr();
    rx_miss = 1'b1; repeat (16'h1FF) tick(); rx_miss = 1'b0;
    chk("R6 count 3FF", {6'd0, miss_count}, 16'h03FF);
    clr();
    rx_miss = 1'b1; tick(); rx_miss = 1'b0;
    chk("R6 wrap count", {6'd0, miss_count}, 16'h0000);
    chk("R6 wrap no overflow", stat_rdata, 16'h040C);
    clr();
    wr_cfg(16'h0000);

    // R7 collision counter
    rx_carrier = 1'b1; tick(); rx_carrier = 1'b0; tick();
    chk("R7 idle carrier ignored", {6'd0, col_count}, 16'h0000);
    rx_carrier = 1'b1; tick(); tx_busy = 1'b1; repeat (3) tick();
    chk("R7 held carrier ignored", {6'd0, col_count}, 16'h0000);
    rx_carrier = 1'b0; tick();
    for (int k = 0; k < 'h1FF; k++) begin
      rx_carrier = 1'b1; tick(); rx_carrier = 1'b0; tick();
    end
    chk("R7 count 1FF", {6'd0, col_count}, 16'h01FF);
    chk("R7 no overflow yet", stat_rdata, 16'h000C);
    rx_carrier = 1'b1; tick();
    chk("R7 overflow bit", stat_rdata, 16'h200C);
    chk("R7 count 200", {6'd0, col_count}, 16'h0200);
    rx_carrier = 1'b0; tx_busy = 1'b0; tick();
    clr();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule